// File: doc/BRIEF.md
# Address-Phase Slave Select Decoder

This block turns the address bus of a pipelined on-chip bus into one select wire per slave. A parameter list describes a set of address windows, each a power-of-two size on a base aligned to that size. A comparator per window checks the address bits above the window size against the window's base. Each match bit drives that slave's own select output. A separate default-slave select is raised whenever no window claims the address.

The decoder has no clock and holds no state. The select vector follows the address within the same cycle, so a slave sees its select in the address phase alongside the address and control it samples at the end of that phase. Qualifying the select with the transfer type, and registering it for the data phase, are left to each slave.

The window table is checked during elaboration. A build stops with an error if two windows share any address, or if a base is not aligned to its window size. With a valid table, the vector formed by the window selects plus the default select has exactly one bit high for every address.

Top module: `ahb_slave_sel`

## Requirements
- R1: Window select bit i is 1 exactly when the address lies in the range from window i's base up to base plus 2 to the power of its size exponent, minus one. Bit i of `region_sel` belongs to window i.
- R2: For any address, no more than one bit of `region_sel` is 1.
- R3: `dflt_sel` is 1 exactly when every bit of `region_sel` is 0.
- R4: The 1 + NUM_REGIONS bit vector {`dflt_sel`, `region_sel`} always has exactly one bit set.
- R5: Select outputs are combinational. A new address shows its selection before the next clock edge, and no earlier address has any effect on it.
- R6: Address bits below a window's size exponent have no effect on that window's select. Any offset inside a window selects the same output.
- R7: At a window edge, the last address inside the window selects it, and the address one past the end selects the next window or the default slave. The address one below the base selects the previous window or the default slave.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| haddr | input | ADDR_W | Address bus during the address phase |
| region_sel | output | NUM_REGIONS | Per-window select, bit i for window i |
| dflt_sel | output | 1 | Default-slave select, high when no window matches |

## Verification
The bench builds the decoder with four windows in a 32-bit space. Two 4 KiB windows sit back to back at the bottom of the map, so one edge falls straight from one window into the next. A 64 KiB window is surrounded by unmapped gaps. A window with exponent 31 covers the whole upper half of the space, so the all-ones address and the midpoint of the space are both exercised. The address sequence crosses every window edge in both directions and lands in each gap. It also changes the address between clock edges to show there is no register stage.

// File: rtl/ahb_sel_pkg.sv
package ahb_sel_pkg;

  localparam int unsigned WIDE_W = 64;

  typedef logic [WIDE_W-1:0] wide_addr_t;

  // Bits at and above the exponent are kept; all lower bits are cleared.
  function automatic wide_addr_t tag_mask(input int unsigned log2sz);
    wide_addr_t m;
    m = '1;
    if (log2sz >= WIDE_W) begin
      m = '0;
    end else begin
      m = m << log2sz;
    end
    return m;
  endfunction

  // Two aligned power-of-two windows share an address exactly when their
  // bases agree on every bit above the larger of the two exponents.
  function automatic bit windows_overlap(input wide_addr_t base_a,
                                         input int unsigned log2_a,
                                         input wide_addr_t base_b,
                                         input int unsigned log2_b);
    int unsigned wider;
    wider = (log2_a > log2_b) ? log2_a : log2_b;
    return ((base_a ^ base_b) & tag_mask(wider)) == '0;
  endfunction

  function automatic bit base_is_aligned(input wide_addr_t base,
                                         input int unsigned log2sz);
    return (base & ~tag_mask(log2sz)) == '0;
  endfunction

endpackage

// File: rtl/ahb_sel_window_cmp.sv
module ahb_sel_window_cmp #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned SIZE_L2 = 12,
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input  logic [ADDR_W-1:0] haddr,
  output logic              hit
);

  localparam ahb_sel_pkg::wide_addr_t WIDE_MASK = ahb_sel_pkg::tag_mask(SIZE_L2);
  localparam logic [ADDR_W-1:0]       TAG_MASK  = WIDE_MASK[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0]       TAG_BITS  = BASE & TAG_MASK;

  always_comb begin
    hit = ((haddr & TAG_MASK) == TAG_BITS);
  end

endmodule

// File: rtl/ahb_sel_fallback.sv
module ahb_sel_fallback #(
  parameter int unsigned NUM_REGIONS = 4
) (
  input  logic [NUM_REGIONS-1:0] hits,
  output logic                   dflt
);

  always_comb begin
    dflt = ~(|hits);
  end

endmodule

// File: rtl/ahb_slave_sel.sv
module ahb_slave_sel #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned NUM_REGIONS = 4,
  parameter logic [NUM_REGIONS-1:0][ADDR_W-1:0] REGION_BASE = {
    32'h8000_0000, 32'h4000_0000, 32'h0001_0000, 32'h0000_0000},
  parameter logic [NUM_REGIONS-1:0][7:0] REGION_L2 = {
    8'd28, 8'd20, 8'd16, 8'd12}
) (
  input  logic [ADDR_W-1:0]      haddr,
  output logic [NUM_REGIONS-1:0] region_sel,
  output logic                   dflt_sel
);

  logic [NUM_REGIONS-1:0] win_hit;

  // Comparator bank, one per window
  for (genvar gi = 0; gi < NUM_REGIONS; gi++) begin : g_win
    localparam int unsigned L2_I = int'(REGION_L2[gi]);

    if (L2_I > ADDR_W) begin : g_bad_size
      $error("window %0d size exponent exceeds address width", gi);
    end

    if (!ahb_sel_pkg::base_is_aligned(
          ahb_sel_pkg::wide_addr_t'(REGION_BASE[gi]), L2_I)) begin : g_bad_align
      $error("window %0d base is not aligned to its size", gi);
    end

    for (genvar gj = gi + 1; gj < NUM_REGIONS; gj++) begin : g_pair
      if (ahb_sel_pkg::windows_overlap(
            ahb_sel_pkg::wide_addr_t'(REGION_BASE[gi]), L2_I,
            ahb_sel_pkg::wide_addr_t'(REGION_BASE[gj]), int'(REGION_L2[gj]))) begin : g_overlap
        $error("windows %0d and %0d overlap", gi, gj);
      end
    end

    ahb_sel_window_cmp #(
      .ADDR_W (ADDR_W),
      .SIZE_L2(L2_I),
      .BASE   (REGION_BASE[gi])
    ) u_cmp (
      .haddr(haddr),
      .hit  (win_hit[gi])
    );
  end

  ahb_sel_fallback #(
    .NUM_REGIONS(NUM_REGIONS)
  ) u_fallback (
    .hits(win_hit),
    .dflt(dflt_sel)
  );

  assign region_sel = win_hit;

endmodule

// File: rtl/ahb_slave_sel_chk.sv
module ahb_slave_sel_chk #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned NUM_REGIONS = 4,
  parameter logic [NUM_REGIONS-1:0][ADDR_W-1:0] REGION_BASE = '0,
  parameter logic [NUM_REGIONS-1:0][7:0]        REGION_L2   = '0
) (
  input logic [ADDR_W-1:0]      haddr,
  input logic [NUM_REGIONS-1:0] region_sel,
  input logic                   dflt_sel
);

  // Range form of the map: lowest and highest address of each window
  function automatic logic [NUM_REGIONS-1:0] in_windows(input logic [ADDR_W-1:0] a);
    logic [NUM_REGIONS-1:0] r;
    logic [64:0] lo, hi, av;
    r  = '0;
    av = 65'(a);
    for (int i = 0; i < NUM_REGIONS; i++) begin
      lo = 65'(REGION_BASE[i]);
      hi = lo + (65'd1 << REGION_L2[i]) - 65'd1;
      r[i] = (av >= lo) && (av <= hi);
    end
    return r;
  endfunction

  logic [NUM_REGIONS-1:0] ref_hit;

  always_comb begin
    ref_hit = in_windows(haddr);
  end

  always_comb begin
    p_region_match_r1: assert (region_sel == ref_hit)
      else $error("window select disagrees with address range");
    p_no_multi_r2: assert ($onehot0(region_sel))
      else $error("more than one window selected");
    p_default_r3: assert (dflt_sel == (ref_hit == '0))
      else $error("default select wrong");
    p_onehot_r4: assert ($countones({dflt_sel, region_sel}) == 1)
      else $error("select vector not one-hot");
  end

endmodule

bind ahb_slave_sel ahb_slave_sel_chk #(
  .ADDR_W     (ADDR_W),
  .NUM_REGIONS(NUM_REGIONS),
  .REGION_BASE(REGION_BASE),
  .REGION_L2  (REGION_L2)
) chk_i (
  .haddr     (haddr),
  .region_sel(region_sel),
  .dflt_sel  (dflt_sel)
);

// File: tb/ahb_slave_sel_tb_top.sv
module ahb_slave_sel_tb_top;

  localparam int unsigned AW = 32;
  localparam int unsigned NR = 4;
  localparam logic [NR-1:0][AW-1:0] MAP_BASE = {
    32'h8000_0000, 32'h0001_0000, 32'h0000_1000, 32'h0000_0000};
  localparam logic [NR-1:0][7:0] MAP_L2 = {8'd31, 8'd16, 8'd12, 8'd12};

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] haddr;
  logic [NR-1:0] region_sel;
  logic          dflt_sel;

  int total;
  int bad;
  bit done;

  typedef struct {
    logic [AW-1:0] addr;
    logic [NR-1:0] exp_sel;
    logic          exp_dflt;
    string         req;
  } item_t;

  item_t sb_q[$];

  ahb_slave_sel #(
    .ADDR_W     (AW),
    .NUM_REGIONS(NR),
    .REGION_BASE(MAP_BASE),
    .REGION_L2  (MAP_L2)
  ) dut_i (
    .haddr     (haddr),
    .region_sel(region_sel),
    .dflt_sel  (dflt_sel)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Reference: plain range test per window
  function automatic logic [NR-1:0] model(input logic [AW-1:0] a);
    logic [NR-1:0] r;
    longint unsigned lo, hi;
    r = '0;
    for (int i = 0; i < NR; i++) begin
      lo = longint'(MAP_BASE[i]);
      hi = lo + (64'd1 << MAP_L2[i]) - 64'd1;
      r[i] = (longint'(a) >= lo) && (longint'(a) <= hi);
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: new address just after a rising edge, expectation queued
  task automatic drive(input logic [AW-1:0] a, input string req);
    item_t it;
    @(posedge clk);
    #1;
    haddr       = a;
    it.addr     = a;
    it.exp_sel  = model(a);
    it.exp_dflt = (model(a) == '0);
    it.req      = req;
    sb_q.push_back(it);
  endtask

  // Monitor: compare at the falling edge of the same cycle
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check($sformatf("%s sel @%h", it.req, it.addr), 32'(region_sel), 32'(it.exp_sel));
        check($sformatf("%s dflt @%h", it.req, it.addr), 32'(dflt_sel), 32'(it.exp_dflt));
        check($sformatf("R4 onehot @%h", it.addr), 32'($countones({dflt_sel, region_sel})), 32'd1);
        check($sformatf("R2 multi @%h", it.addr), 32'($onehot0(region_sel)), 32'd1);
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0;
    bad   = 0;
    done  = 1'b0;
    rst_n = 1'b0;
    haddr = '0;
    repeat (3) @(posedge clk);
    #1;
    // Reset state: address zero lies in window 0
    check("R1 reset sel", 32'(region_sel), 32'h1);
    check("R3 reset dflt", 32'(dflt_sel), 32'h0);
    rst_n = 1'b1;

    drive(32'h0000_0000, "R1");
    drive(32'h0000_0FFF, "R7");
    drive(32'h0000_1000, "R7");
    drive(32'h0000_1FFF, "R7");
    drive(32'h0000_2000, "R3");
    drive(32'h0000_1001, "R6");
    drive(32'h0000_17A5, "R6");
    drive(32'h0000_0ABC, "R6");
    drive(32'h0000_FFFF, "R7");
    drive(32'h0001_0000, "R7");
    drive(32'h0001_8001, "R6");
    drive(32'h0001_FFFF, "R7");
    drive(32'h0002_0000, "R3");
    drive(32'h7FFF_FFFF, "R7");
    drive(32'h8000_0000, "R7");
    drive(32'hFFFF_FFFF, "R1");
    drive(32'h1234_5678, "R3");
    drive(32'hC000_0004, "R6");
    // Alternating jumps: result must not depend on the previous address
    for (int k = 0; k < 8; k++) begin
      drive((k % 2 == 0) ? 32'h0001_0040 : 32'h0000_1040, "R5");
    end

    // Mid-cycle change: no clock edge between drive and sample
    @(posedge clk);
    #1;
    haddr = 32'h0000_2400;
    #0.5;
    check("R5 mid-cycle dflt", 32'(dflt_sel), 32'h1);
    haddr = 32'h8765_4321;
    #0.5;
    check("R5 mid-cycle sel", 32'(region_sel), 32'h8);

    while (sb_q.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule